// File: doc/BRIEF.md
# Static-Prediction Fetch Redirect Unit

This block chooses the next fetch address for a five-stage, 32-bit, in-order pipeline. It also produces the flush controls that pipeline needs. In the fetch stage a pre-decoder flags a branch and supplies its 16-bit word offset. The block then guesses the branch direction with a fixed rule and steers fetch down the guessed path in the same cycle. Two rules are available, chosen by a mode input. In the first, every branch is assumed to fall through. In the second, a backward branch (negative offset) is assumed taken and a forward branch is assumed not taken.

Each guess is recorded in a small in-order queue, together with the branch's fall-through address. When the pipeline later reports the real outcome of the oldest unresolved branch, the block compares that outcome with the recorded guess. On a match nothing is lost. On a mismatch the block does four things in that same cycle:
- it overrides the next fetch address with the correct path;
- it raises one flush bit per wrong-path pipeline register;
- it forces the control fields of those registers to zero, so the wrong-path instructions become bubbles before any of them can write the register file or memory;
- it discards every younger recorded guess.

A parameter selects where branches resolve. Resolving in decode squashes only the one instruction behind the branch. Resolving late squashes three.

Top module: `fetch_redirect_unit`

## Requirements
- R1: When no redirect occurs and the fetched word is not a branch guessed taken, `next_pc` equals `fetch_pc + 4`.
- R2: With `mode_dir = 0`, every branch is guessed not taken: `pred_taken` is 0 and `next_pc` is `fetch_pc + 4`.
- R3: With `mode_dir = 1`, a branch whose offset bit 15 is 1 is guessed taken. For that branch `next_pc = fetch_pc + 4 + (sign-extended offset << 2)`. An offset with bit 15 equal to 0, including zero, is guessed not taken.
- R4: When the reported outcome equals the recorded guess, `mispredict` is 0, all flush bits are 0, and `next_pc` follows R1 to R3 for the current fetch. No cycle is lost.
- R5: When the reported outcome differs from the recorded guess, `mispredict` is 1 in the same cycle as `res_valid`. In that cycle `next_pc` is `res_target` if the branch was taken, and the branch's own PC + 4 if it was not.
- R6: A redirect has priority over a taken guess for a branch fetched in the same cycle. That branch is not recorded, so a later outcome report has nothing to match.
- R7: The flush vector has bit 0 for IF/ID, bit 1 for ID/EX and bit 2 for EX/MEM. On a mispredict with `RESOLVE_LATE = 1`, all three bits are 1. With `RESOLVE_LATE = 0`, the vector is one bit wide and that bit is 1. The number of set bits is the number of cycles lost.
- R8: Each stage slice of `stage_ctrl_o` (slice i at bits `i*CTRL_W` upward) is all zero when flush bit i is 1. Otherwise it equals the matching slice of `stage_ctrl_i`.
- R9: Outcome reports are matched to recorded guesses oldest first. A mispredict discards all younger recorded guesses. A report that arrives while nothing is recorded is ignored: `mispredict` stays 0.
- R10: After reset nothing is recorded, so an outcome report causes no mispredict and no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_dir | input | 1 | 1 selects the backward-taken / forward-not-taken rule; 0 selects always-not-taken |
| fetch_valid | input | 1 | A word is being fetched this cycle |
| fetch_pc | input | PC_W | Address of the fetched word |
| fetch_is_br | input | 1 | Pre-decode marks the fetched word as a conditional branch |
| fetch_off | input | OFF_W | Signed word offset of that branch |
| res_valid | input | 1 | The oldest unresolved branch reports its outcome |
| res_taken | input | 1 | Reported outcome, 1 = taken |
| res_target | input | PC_W | Computed target of the reported branch |
| stage_ctrl_i | input | NSQ*CTRL_W | Control fields of the pipeline registers that may be squashed |
| next_pc | output | PC_W | Address to fetch next |
| pred_taken | output | 1 | Direction guess for the current fetch |
| mispredict | output | 1 | Reported outcome contradicts the recorded guess |
| flush_vec | output | NSQ | Per-register squash request |
| stage_ctrl_o | output | NSQ*CTRL_W | Control fields after squashing |

## Verification
The bench sweeps offsets on both sides of the sign boundary, in both modes and for both resolve depths. It includes offsets 0, 0x7FFF, 0x8000 and 0xFFFF. A design that tested the wrong bit, or treated a zero offset as backward, would guess the wrong direction. A design that shifted or sign-extended the offset wrongly would fetch from a bad target. Directed sequences cover four further corner cases:
- a redirect that lands in the same cycle as a taken guess, where a design giving the guess priority would fetch the wrong path;
- two branches in flight, to show that outcomes pair with guesses oldest first;
- a mispredict with younger guesses still recorded, where a design that kept the stale guesses would raise a false second mispredict;
- resolutions right after reset.

The total of lost cycles is compared with three (or one) times the number of wrong guesses, and every squashed control field is checked for zero.

// File: rtl/fsu_pkg.sv
// Package: shared constants and helpers for the fetch redirect unit.
// Assumes: pipeline registers are numbered from the fetch side outward.
package fsu_pkg;

    localparam int unsigned FSU_PC_W   = 32;
    localparam int unsigned FSU_OFF_W  = 16;
    localparam int unsigned FSU_QDEPTH = 4;
    localparam int unsigned FSU_CTRL_W = 8;

    // Index of each squashable pipeline register in the flush vector.
    typedef enum int unsigned {
        STG_IFID  = 0,
        STG_IDEX  = 1,
        STG_EXMEM = 2
    } fsu_stage_e;

    // Number of wrong-path registers for a given resolve point.
    function automatic int unsigned fsu_squash_depth(input bit late);
        return late ? 3 : 1;
    endfunction

endpackage

// File: rtl/fsu_guess.sv
// Module: fsu_guess
// Computes the sequential address, the branch target and the static
// direction guess for the word in fetch. Purely combinational.
// Assumes: the offset counts words, so it is shifted left by two, and
// PC_W > OFF_W + 2.
module fsu_guess #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned OFF_W = 16
) (
    input  logic             mode_dir,
    input  logic             is_br,
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] off,
    output logic [PC_W-1:0]  seq_pc,
    output logic [PC_W-1:0]  tgt_pc,
    output logic             guess_taken
);

    localparam int unsigned EXT_W = PC_W - OFF_W - 2;

    logic [PC_W-1:0] off_bytes;
    logic            backward;

    // Sign-extend the word offset and turn it into a byte offset.
    always_comb begin
        off_bytes = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
    end

    // Fall-through and taken-path addresses.
    always_comb begin
        seq_pc = pc + PC_W'(4);
        tgt_pc = seq_pc + off_bytes;
    end

    // Direction rule: only backward branches, and only in direction mode.
    always_comb begin
        backward    = off[OFF_W-1];
        guess_taken = is_br & mode_dir & backward;
    end

endmodule

// File: rtl/fsu_queue.sv
// Module: fsu_queue
// In-order record of unresolved guesses. Push at the tail, pop at the
// head, and a clear that empties it in one cycle.
// Assumes: the caller never pops when empty and never pushes when full
// without popping in the same cycle. Clear wins over push and pop.
module fsu_queue #(
    parameter int unsigned W     = 33,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;
    logic [CW-1:0] cnt;

    // Wrap a pointer at the configured depth, which need not be a power of two.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Storage write on push. Entries need no reset.
    always_ff @(posedge clk) begin
        if (push && !clear) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointer and occupancy update, with a synchronous reset and clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // Head data and occupancy flags.
    always_comb begin
        dout  = mem[rd_ptr];
        empty = (cnt == '0);
        full  = (cnt == CW'(DEPTH));
    end

endmodule

// File: rtl/fsu_squash.sv
// Module: fsu_squash
// Turns a kill request into per-register flush bits and zeroes the
// control field of each flushed register.
// Assumes: every wrong-path register sits between fetch and the resolve
// point, so all NSQ of them are flushed together.
module fsu_squash #(
    parameter int unsigned NSQ    = 3,
    parameter int unsigned CTRL_W = 8
) (
    input  logic                  kill,
    input  logic [NSQ*CTRL_W-1:0] ctrl_i,
    output logic [NSQ-1:0]        flush_vec,
    output logic [NSQ*CTRL_W-1:0] ctrl_o
);

    for (genvar g = 0; g < NSQ; g++) begin : g_stage
        // One register slot: raise its flush bit and zero its control field.
        always_comb begin
            flush_vec[g]                 = kill;
            ctrl_o[g*CTRL_W +: CTRL_W]   = kill ? '0 : ctrl_i[g*CTRL_W +: CTRL_W];
        end
    end

endmodule

// File: rtl/fetch_redirect_unit.sv
// Module: fetch_redirect_unit (top)
// Selects the next fetch address from PC+4, a statically guessed branch
// target, or a redirect after a wrong guess. Produces the flush and
// control-squash outputs for the wrong-path registers.
// Assumes: outcomes arrive oldest first, at most QDEPTH branches are in
// flight, and res_target is the branch's computed target.
module fetch_redirect_unit
    import fsu_pkg::*;
#(
    parameter int unsigned PC_W         = FSU_PC_W,
    parameter int unsigned OFF_W        = FSU_OFF_W,
    parameter int unsigned QDEPTH       = FSU_QDEPTH,
    parameter int unsigned CTRL_W       = FSU_CTRL_W,
    parameter bit          RESOLVE_LATE = 1'b1,
    localparam int unsigned NSQ         = fsu_squash_depth(RESOLVE_LATE)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_dir,
    input  logic                  fetch_valid,
    input  logic [PC_W-1:0]       fetch_pc,
    input  logic                  fetch_is_br,
    input  logic [OFF_W-1:0]      fetch_off,
    input  logic                  res_valid,
    input  logic                  res_taken,
    input  logic [PC_W-1:0]       res_target,
    input  logic [NSQ*CTRL_W-1:0] stage_ctrl_i,
    output logic [PC_W-1:0]       next_pc,
    output logic                  pred_taken,
    output logic                  mispredict,
    output logic [NSQ-1:0]        flush_vec,
    output logic [NSQ*CTRL_W-1:0] stage_ctrl_o
);

    localparam int unsigned REC_W = 1 + PC_W;

    logic [PC_W-1:0]  seq_pc;
    logic [PC_W-1:0]  tgt_pc;
    logic             guess;
    logic [REC_W-1:0] rec_in;
    logic [REC_W-1:0] rec_head;
    logic             head_taken;
    logic [PC_W-1:0]  head_fall;
    logic             q_empty;
    logic             q_full;
    logic             q_push;
    logic             q_pop;
    logic             resolve_hit;
    logic [PC_W-1:0]  redirect_pc;

    fsu_guess #(
        .PC_W  (PC_W),
        .OFF_W (OFF_W)
    ) u_guess (
        .mode_dir    (mode_dir),
        .is_br       (fetch_is_br),
        .pc          (fetch_pc),
        .off         (fetch_off),
        .seq_pc      (seq_pc),
        .tgt_pc      (tgt_pc),
        .guess_taken (guess)
    );

    // Pack the record: the guess and the branch's fall-through address.
    always_comb begin
        rec_in     = {guess, seq_pc};
        head_taken = rec_head[REC_W-1];
        head_fall  = rec_head[PC_W-1:0];
    end

    // Compare the reported outcome against the oldest recorded guess.
    always_comb begin
        resolve_hit = res_valid & ~q_empty;
        mispredict  = resolve_hit & (res_taken != head_taken);
        redirect_pc = res_taken ? res_target : head_fall;
    end

    // Queue control: a wrong guess drops the fetch and discards younger records.
    always_comb begin
        q_push = fetch_valid & fetch_is_br & ~mispredict;
        q_pop  = resolve_hit & ~mispredict;
    end

    fsu_queue #(
        .W     (REC_W),
        .DEPTH (QDEPTH)
    ) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (mispredict),
        .push  (q_push),
        .pop   (q_pop),
        .din   (rec_in),
        .dout  (rec_head),
        .empty (q_empty),
        .full  (q_full)
    );

    // Next-address priority: redirect first, then a taken guess, then PC+4.
    always_comb begin
        pred_taken = fetch_valid & guess;
        if (mispredict) begin
            next_pc = redirect_pc;
        end else if (pred_taken) begin
            next_pc = tgt_pc;
        end else begin
            next_pc = seq_pc;
        end
    end

    fsu_squash #(
        .NSQ    (NSQ),
        .CTRL_W (CTRL_W)
    ) u_squash (
        .kill      (mispredict),
        .ctrl_i    (stage_ctrl_i),
        .flush_vec (flush_vec),
        .ctrl_o    (stage_ctrl_o)
    );

endmodule

// File: rtl/fsu_checker.sv
// Module: fsu_checker
// Concurrent checks on the fetch redirect unit, attached by bind.
// Assumes: it is bound to every instance of fetch_redirect_unit.
module fsu_checker #(
    parameter int unsigned PC_W   = 32,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned NSQ    = 3,
    parameter int unsigned CTRL_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  mode_dir,
    input logic                  fetch_valid,
    input logic [PC_W-1:0]       fetch_pc,
    input logic                  fetch_is_br,
    input logic [OFF_W-1:0]      fetch_off,
    input logic                  res_valid,
    input logic                  res_taken,
    input logic [PC_W-1:0]       res_target,
    input logic [PC_W-1:0]       next_pc,
    input logic                  pred_taken,
    input logic                  mispredict,
    input logic [NSQ-1:0]        flush_vec,
    input logic [NSQ*CTRL_W-1:0] stage_ctrl_o,
    input logic                  q_empty,
    input logic                  q_full,
    input logic                  q_push,
    input logic                  q_pop
);

    // R1: plain sequential fetch
    p_seq_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !fetch_is_br && !mispredict) |-> (next_pc == fetch_pc + PC_W'(4)));

    // R2: the always-not-taken mode never guesses taken
    p_ant_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_dir |-> !pred_taken);

    // R3: forward branches are never guessed taken
    p_fwd_not_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_is_br && !fetch_off[OFF_W-1]) |-> !pred_taken);

    // R4: no flush without a wrong guess
    p_idle_no_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mispredict |-> (flush_vec == '0));

    // R5: a taken redirect goes to the resolved target
    p_redirect_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mispredict && res_taken) |-> (next_pc == res_target));

    // R5: a wrong guess needs an outcome report
    p_misp_needs_report_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> res_valid);

    // R7: every wrong-path register is flushed
    p_flush_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> ($countones(flush_vec) == NSQ));

    // R8: flushed registers carry zero control
    for (genvar g = 0; g < NSQ; g++) begin : g_ctrl
        p_ctrl_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            flush_vec[g] |-> (stage_ctrl_o[g*CTRL_W +: CTRL_W] == '0));
    end

    // R9: a wrong guess leaves no younger record behind
    p_kill_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |=> q_empty);

    // R9: the record queue is never pushed past capacity
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push && q_full) |-> q_pop);

    // R10: with nothing recorded, a report has no effect
    p_empty_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |-> !mispredict);

endmodule

bind fetch_redirect_unit fsu_checker #(
    .PC_W   (PC_W),
    .OFF_W  (OFF_W),
    .NSQ    (NSQ),
    .CTRL_W (CTRL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_dir     (mode_dir),
    .fetch_valid  (fetch_valid),
    .fetch_pc     (fetch_pc),
    .fetch_is_br  (fetch_is_br),
    .fetch_off    (fetch_off),
    .res_valid    (res_valid),
    .res_taken    (res_taken),
    .res_target   (res_target),
    .next_pc      (next_pc),
    .pred_taken   (pred_taken),
    .mispredict   (mispredict),
    .flush_vec    (flush_vec),
    .stage_ctrl_o (stage_ctrl_o),
    .q_empty      (q_empty),
    .q_full       (q_full),
    .q_push       (q_push),
    .q_pop        (q_pop)
);

// File: tb/sim_fetch_redirect_unit.sv
// Bench: sweeps branch offsets in both guess modes and drives both
// resolve depths with the same stimulus (u0 late, u1 early). It then
// runs directed ordering, priority and reset sequences.
module sim_fetch_redirect_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_dir = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        fetch_is_br = 1'b0;
    logic [15:0] fetch_off = '0;
    logic        res_valid = 1'b0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;

    localparam logic [23:0] CTRL0 = 24'hA53CF1;
    localparam logic [7:0]  CTRL1 = 8'h5A;

    logic [31:0] npc0, npc1;
    logic        pt0, pt1, mis0, mis1;
    logic [2:0]  fl0;
    logic [0:0]  fl1;
    logic [23:0] co0;
    logic [7:0]  co1;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    fetch_redirect_unit #(.RESOLVE_LATE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_dir(mode_dir),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_is_br(fetch_is_br), .fetch_off(fetch_off),
        .res_valid(res_valid), .res_taken(res_taken), .res_target(res_target),
        .stage_ctrl_i(CTRL0), .next_pc(npc0), .pred_taken(pt0),
        .mispredict(mis0), .flush_vec(fl0), .stage_ctrl_o(co0)
    );

    fetch_redirect_unit #(.RESOLVE_LATE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .mode_dir(mode_dir),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_is_br(fetch_is_br), .fetch_off(fetch_off),
        .res_valid(res_valid), .res_taken(res_taken), .res_target(res_target),
        .stage_ctrl_i(CTRL1), .next_pc(npc1), .pred_taken(pt1),
        .mispredict(mis1), .flush_vec(fl1), .stage_ctrl_o(co1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs just after a falling edge; outputs settle by #2.
    task automatic drive(input bit fv, input bit br, input logic [31:0] pc,
                         input logic [15:0] off, input bit rv, input bit rt,
                         input logic [31:0] rtg);
        @(negedge clk);
        fetch_valid = fv; fetch_is_br = br; fetch_pc = pc; fetch_off = off;
        res_valid = rv; res_taken = rt; res_target = rtg;
        #2;
    endtask

    function automatic logic [31:0] tgt_of(input logic [31:0] pc, input logic [15:0] off);
        return pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired before the run completed");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int lost;
        int wrong;
        logic [15:0] off;
        logic [31:0] pc, tgt;
        bit g, t, mis;
        lost = 0;
        wrong = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reports right after reset have nothing to match
        drive(1'b0, 1'b0, 32'h0, 16'h0, 1'b1, 1'b1, 32'h1234);
        check("R10 mispredict after reset u0", 32'(mis0), 32'd0);
        check("R10 mispredict after reset u1", 32'(mis1), 32'd0);
        check("R10 flush after reset u0", 32'(fl0), 32'd0);
        drive(1'b1, 1'b0, 32'h100, 16'h0, 1'b1, 1'b0, 32'h0);
        check("R10 no-taken report after reset", 32'(mis0), 32'd0);
        check("R1 sequential after reset", npc0, 32'h104);

        // Sweep: one branch fetched, then resolved on the next cycle
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 48; k++) begin
                off = (k == 0) ? 16'h0000 : (k == 1) ? 16'h7FFF :
                      (k == 2) ? 16'h8000 : (k == 3) ? 16'hFFFF : 16'(k * 1399);
                pc  = 32'h0040_0000 + 32'(k * 64) + 32'(m * 32'h10000);
                tgt = tgt_of(pc, off);
                g   = (m == 1) && off[15];
                t   = (k % 3) == 0;
                mis = (t != g);
                mode_dir = (m == 1);

                drive(1'b1, 1'b1, pc, off, 1'b0, 1'b0, 32'h0);
                if (m == 0) begin
                    check("R2 guess in not-taken mode u0", 32'(pt0), 32'd0);
                    check("R2 next_pc in not-taken mode", npc0, pc + 32'd4);
                end else begin
                    check("R3 direction guess u0", 32'(pt0), 32'(g));
                    check("R3 next_pc from guess", npc0, g ? tgt : pc + 32'd4);
                end
                check("R3 direction guess u1", 32'(pt1), 32'(g));

                drive(1'b1, 1'b0, pc + 32'h100, 16'h0, 1'b1, t, tgt);
                if (mis) begin
                    wrong++;
                    check("R5 mispredict raised u0", 32'(mis0), 32'd1);
                    check("R5 redirect address", npc0, t ? tgt : pc + 32'd4);
                    check("R7 late flush vector", 32'(fl0), 32'd7);
                    check("R7 early flush vector", 32'(fl1), 32'd1);
                    check("R8 late ctrl squashed", 32'(co0), 32'd0);
                    check("R8 early ctrl squashed", 32'(co1), 32'd0);
                end else begin
                    check("R4 no mispredict u0", 32'(mis0), 32'd0);
                    check("R4 fetch continues", npc0, pc + 32'h104);
                    check("R4 late flush idle", 32'(fl0), 32'd0);
                    check("R4 early flush idle", 32'(fl1), 32'd0);
                    check("R8 late ctrl passes", 32'(co0), 32'(CTRL0));
                    check("R8 early ctrl passes", 32'(co1), 32'(CTRL1));
                end
                check("R5 mispredict u1", 32'(mis1), 32'(mis));
                lost += $countones(fl0);
            end
        end
        check("R7 lost cycles total late", 32'(lost), 32'(wrong * 3));

        mode_dir = 1'b1;

        // R6: a redirect beats a same-cycle taken guess; that branch is dropped
        drive(1'b1, 1'b1, 32'h1000, 16'hFFF0, 1'b0, 1'b0, 32'h0);
        check("R3 backward guessed taken", npc0, tgt_of(32'h1000, 16'hFFF0));
        drive(1'b1, 1'b1, 32'h2000, 16'hFF00, 1'b1, 1'b0, 32'h0);
        check("R6 redirect wins over guess", npc0, 32'h1004);
        check("R6 redirect wins u1", npc1, 32'h1004);
        drive(1'b0, 1'b0, 32'h0, 16'h0, 1'b1, 1'b1, tgt_of(32'h2000, 16'hFF00));
        check("R6 dropped branch not recorded", 32'(mis0), 32'd0);

        // R9: two in flight, matched oldest first
        drive(1'b1, 1'b1, 32'h3000, 16'h0010, 1'b0, 1'b0, 32'h0);
        drive(1'b1, 1'b1, 32'h3100, 16'hFFFC, 1'b0, 1'b0, 32'h0);
        drive(1'b0, 1'b0, 32'h0, 16'h0, 1'b1, 1'b0, tgt_of(32'h3000, 16'h0010));
        check("R9 oldest matches guess", 32'(mis0), 32'd0);
        drive(1'b0, 1'b0, 32'h0, 16'h0, 1'b1, 1'b0, tgt_of(32'h3100, 16'hFFFC));
        check("R9 second resolves wrong", 32'(mis0), 32'd1);
        check("R9 second redirect fall-through", npc0, 32'h3104);
        check("R7 second flush late", 32'(fl0), 32'd7);

        // R9: a wrong guess discards the younger record
        drive(1'b1, 1'b1, 32'h4000, 16'hFFF8, 1'b0, 1'b0, 32'h0);
        drive(1'b1, 1'b1, 32'h4010, 16'h0008, 1'b0, 1'b0, 32'h0);
        drive(1'b0, 1'b0, 32'h0, 16'h0, 1'b1, 1'b0, tgt_of(32'h4000, 16'hFFF8));
        check("R9 first wrong", 32'(mis0), 32'd1);
        check("R9 first redirect", npc0, 32'h4004);
        drive(1'b0, 1'b0, 32'h0, 16'h0, 1'b1, 1'b1, tgt_of(32'h4010, 16'h0008));
        check("R9 younger record discarded u0", 32'(mis0), 32'd0);
        check("R9 younger record discarded u1", 32'(mis1), 32'd0);
        check("R9 no flush on ignored report", 32'(fl0), 32'd0);

        drive(1'b0, 1'b0, 32'h0, 16'h0, 1'b0, 1'b0, 32'h0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule